// File: doc/BRIEF.md
# Serial Receive Shift and Buffer

This block is the receive datapath of a serial port that runs either as an asynchronous UART or as a clock-synchronous link. On every bit strobe it takes one bit from the serial input into a shift register. When the configured number of bits has arrived, it copies the assembled word into a 16-bit buffer, given as a low byte and a high byte. The content of the high byte depends on the data length. In synchronous mode with MSB-first order, the low byte is bit-reversed.

Software-side logic reads the low byte and pulses a read strobe, which clears the buffer-full flag. If a second word completes while the first is still unread, the buffer is overwritten and a sticky overrun flag is raised. Dropping the receive enable and raising it again clears the partial word, the buffer and both flags. Baud timing, framing checks and interrupts are handled elsewhere.

Top module: `sio_rx_buffer`

## Requirements
- R1: Each bit is captured when `bit_tick` is high, and bits arrive least significant first. The first captured bit becomes bit 0 of the word. `rx_data` is ignored in any cycle where `bit_tick` is low.
- R2: On the clock edge that takes in the last bit of a word, the word is written into `buf_lo`/`buf_hi` and `buf_full` goes to 1. All three are visible right after that edge.
- R3: When 9 bits are used (UART mode, `len_sel`=2'b10), the low byte holds word bits 7..0. Bit 0 of the high byte holds word bit 8, and the other high-byte bits are 0.
- R4: When 8 bits are used (UART mode with `len_sel` 2'b01 or 2'b11, or synchronous mode), bit 0 of the high byte repeats bit 7 of the low byte as it is presented. The other high-byte bits are 0.
- R5: When 7 bits are used (UART mode, `len_sel`=2'b00), the word fills low-byte bits 6..0 and low-byte bit 7 is 0. Bit 0 of the high byte repeats low-byte bit 6, and the other high-byte bits are 0.
- R6: In synchronous mode (`sync_mode`=1) a word is always 8 bits, whatever `len_sel` holds.
- R7: In synchronous mode with `msb_first`=1, the low byte is presented bit-reversed: the first received bit appears at bit 7. In UART mode `msb_first` has no effect.
- R8: A `rd_lo` pulse clears `buf_full` on the next edge, unless a word completes on that same edge.
- R9: If a word completes while `buf_full` is 1 and `rd_lo` is low, the new word replaces the buffer and `overrun` goes to 1. `overrun` then stays 1 until the receiver is disabled.
- R10: If `rd_lo` is high on the same edge that a word completes, the new word is stored, `buf_full` stays 1 and `overrun` is not set.
- R11: While `rx_en` is 0, the partial word, both buffer bytes, `buf_full` and `overrun` are held at 0, and bit strobes are ignored.
- R12: After reset, the buffer bytes and both flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable; low clears the receiver |
| bit_tick | input | 1 | One-cycle strobe marking a bit to capture |
| rx_data | input | 1 | Serial data input |
| sync_mode | input | 1 | 1 = clock-synchronous, 0 = UART |
| len_sel | input | 2 | UART data length: 00=7, 01=8, 10=9, 11=8 |
| msb_first | input | 1 | Present the low byte reversed (synchronous mode only) |
| rd_lo | input | 1 | Read strobe for the low byte |
| buf_lo | output | 8 | Receive buffer, low byte |
| buf_hi | output | 8 | Receive buffer, high byte |
| buf_full | output | 1 | An unread word is in the buffer |
| overrun | output | 1 | A word was overwritten before it was read |

## Verification
The main path is driven with words of 7, 8 and 9 bits in UART mode, and with 8-bit words in synchronous mode under both bit orders. The data patterns set and clear the top data bit, so the high-byte fill (word bit 8 for 9 bits, a copy of the low byte for 8 and 7 bits) can be told apart from a plain zero. Asymmetric patterns in MSB-first mode expose a missing or misplaced reversal. The same pattern sent with `msb_first` set in UART mode, and synchronous words sent with 7- and 9-bit length codes, show that these settings are ignored where they should be. Directed sequences cover back-to-back words without a read, a read on the completion edge, strobes sent while the receiver is disabled, and the enable toggle.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
    localparam int WORD_MAX = 9;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(WORD_MAX + 1);

    typedef logic [CNT_W-1:0] bitcnt_t;

    // data length codes used while in UART mode
    localparam logic [1:0] LEN_7 = 2'b00;
    localparam logic [1:0] LEN_8 = 2'b01;
    localparam logic [1:0] LEN_9 = 2'b10;

    function automatic bitcnt_t word_bits(input logic sync_m, input logic [1:0] code);
        if (sync_m)            return bitcnt_t'(8);
        else if (code == LEN_7) return bitcnt_t'(7);
        else if (code == LEN_9) return bitcnt_t'(9);
        else                    return bitcnt_t'(8);
    endfunction
endpackage

// File: rtl/sio_rx_shifter.sv
module sio_rx_shifter
    import sio_rx_pkg::*;
#(
    parameter int MAXW = WORD_MAX,
    parameter int CW   = CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    input  logic            din,
    input  logic [CW-1:0]   nbits,
    output logic            done,
    output logic [MAXW-1:0] word
);
    typedef struct packed {
        logic [MAXW-1:0] sr;
        logic [CW-1:0]   cnt;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (tick) begin
            st_d.sr = {din, st_q.sr[MAXW-1:1]};
            if (st_q.cnt >= nbits - CW'(1)) begin
                done     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
        // right-align: first bit received lands at bit 0
        word = st_d.sr >> (CW'(MAXW) - nbits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11
    cnt_cleared_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0 && st_q.sr == '0));
    // R1
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(st_q.sr));
endmodule

// File: rtl/sio_rx_formatter.sv
module sio_rx_formatter
    import sio_rx_pkg::*;
#(
    parameter int MAXW = WORD_MAX,
    parameter int BW   = BYTE_W,
    parameter int CW   = CNT_W
) (
    input  logic [MAXW-1:0] word,
    input  logic [CW-1:0]   nbits,
    input  logic            reverse,
    output logic [BW-1:0]   lo,
    output logic [BW-1:0]   hi
);
    logic [BW-1:0] flipped;

    for (genvar g = 0; g < BW; g++) begin : g_flip
        assign flipped[g] = word[BW-1-g];
    end

    always_comb begin
        lo = reverse ? flipped : word[BW-1:0];
        hi = '0;
        if (nbits == CW'(BW + 1))  hi[0] = word[BW];
        else if (nbits == CW'(BW)) hi[0] = lo[BW-1];
        else                       hi[0] = lo[BW-2];
    end
endmodule

// File: rtl/sio_rx_buffer.sv
module sio_rx_buffer
    import sio_rx_pkg::*;
#(
    parameter int MAXW = WORD_MAX,
    parameter int BW   = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          bit_tick,
    input  logic          rx_data,
    input  logic          sync_mode,
    input  logic [1:0]    len_sel,
    input  logic          msb_first,
    input  logic          rd_lo,
    output logic [BW-1:0] buf_lo,
    output logic [BW-1:0] buf_hi,
    output logic          buf_full,
    output logic          overrun
);
    localparam int CW = $clog2(MAXW + 1);

    typedef struct packed {
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
        logic          full;
        logic          ovr;
    } rxb_t;

    rxb_t st_d, st_q;

    logic [CW-1:0]   nbits;
    logic            done_w;
    logic [MAXW-1:0] word_w;
    logic [BW-1:0]   fmt_lo, fmt_hi;
    logic            rev_w;

    assign nbits = CW'(word_bits(sync_mode, len_sel));
    assign rev_w = sync_mode & msb_first;

    sio_rx_shifter #(.MAXW(MAXW), .CW(CW)) u_shf (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .tick  (bit_tick),
        .din   (rx_data),
        .nbits (nbits),
        .done  (done_w),
        .word  (word_w)
    );

    sio_rx_formatter #(.MAXW(MAXW), .BW(BW), .CW(CW)) u_fmt (
        .word    (word_w),
        .nbits   (nbits),
        .reverse (rev_w),
        .lo      (fmt_lo),
        .hi      (fmt_hi)
    );

    always_comb begin
        st_d = st_q;
        if (!rx_en) begin
            st_d = '0;
        end else begin
            if (rd_lo) st_d.full = 1'b0;
            if (done_w) begin
                st_d.lo   = fmt_lo;
                st_d.hi   = fmt_hi;
                st_d.full = 1'b1;
                if (st_q.full && !rd_lo) st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_lo   = st_q.lo;
    assign buf_hi   = st_q.hi;
    assign buf_full = st_q.full;
    assign overrun  = st_q.ovr;

    // R2
    full_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_w |=> buf_full);
    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !done_w) |=> !buf_full);
    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en) |=> overrun);
    // R9
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(done_w && buf_full && !rd_lo));
    // R11
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!buf_full && !overrun && buf_lo == '0 && buf_hi == '0));
    // R3
    hi_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_hi[BW-1:1] == '0);
endmodule

// File: tb/tb_sio_rx_buffer.sv
`timescale 1ns/1ps
module tb_sio_rx_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, bit_tick = 1'b0, rx_data = 1'b0;
    logic       sync_mode = 1'b0, msb_first = 1'b0, rd_lo = 1'b0;
    logic [1:0] len_sel = 2'b01;
    logic [7:0] buf_lo, buf_hi;
    logic       buf_full, overrun;

    int checks = 0;
    int fails  = 0;
    bit done_run = 1'b0;

    always #4 clk = ~clk;

    sio_rx_buffer dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_tick(bit_tick),
        .rx_data(rx_data), .sync_mode(sync_mode), .len_sel(len_sel),
        .msb_first(msb_first), .rd_lo(rd_lo), .buf_lo(buf_lo),
        .buf_hi(buf_hi), .buf_full(buf_full), .overrun(overrun)
    );

    // {sync, len[1:0], msb, data[8:0], exp_lo, exp_hi}
    localparam int NV = 12;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 2'd1, 1'b0, 9'h0A5, 8'hA5, 8'h01},  // R4
        {1'b0, 2'd1, 1'b0, 9'h03C, 8'h3C, 8'h00},  // R4
        {1'b0, 2'd2, 1'b0, 9'h15A, 8'h5A, 8'h01},  // R3
        {1'b0, 2'd2, 1'b0, 9'h0FF, 8'hFF, 8'h00},  // R3
        {1'b0, 2'd0, 1'b0, 9'h055, 8'h55, 8'h01},  // R5
        {1'b0, 2'd0, 1'b0, 9'h02A, 8'h2A, 8'h00},  // R5
        {1'b0, 2'd1, 1'b1, 9'h001, 8'h01, 8'h00},  // R7 ignored in UART
        {1'b1, 2'd1, 1'b0, 9'h081, 8'h81, 8'h01},  // R4
        {1'b1, 2'd1, 1'b1, 9'h001, 8'h80, 8'h01},  // R7
        {1'b1, 2'd1, 1'b1, 9'h00E, 8'h70, 8'h00},  // R7
        {1'b1, 2'd2, 1'b0, 9'h06B, 8'h6B, 8'h00},  // R6
        {1'b1, 2'd0, 1'b0, 9'h0C5, 8'hC5, 8'h01}   // R6
    };

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compares {lo, hi, full, ovr}
    task automatic check_all(input string req, input logic [7:0] lo, input logic [7:0] hi,
                             input logic full, input logic ovr);
        check(req, {buf_lo, buf_hi, buf_full, overrun}, {lo, hi, full, ovr});
    endtask

    task automatic send_word(input logic [8:0] d, input int n, input bit rd_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_data  = d[i];
            bit_tick = 1'b1;
            rd_lo    = rd_last && (i == n - 1);
            @(negedge clk);
            bit_tick = 1'b0;
            rd_lo    = 1'b0;
            rx_data  = ~d[i];  // noise between strobes (R1)
        end
    endtask

    task automatic read_lo();
        @(negedge clk); rd_lo = 1'b1;
        @(negedge clk); rd_lo = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done_run) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12
        check_all("R12", 8'h00, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        rx_en = 1'b1;

        for (int v = 0; v < NV; v++) begin
            int nb;
            sync_mode = VEC[v][28];
            len_sel   = VEC[v][27:26];
            msb_first = VEC[v][25];
            nb = sync_mode ? 8 : (len_sel == 2'd0 ? 7 : (len_sel == 2'd2 ? 9 : 8));
            send_word(VEC[v][24:16], nb, 1'b0);
            // R1 R2
            check_all($sformatf("R2 vec%0d", v), VEC[v][15:8], VEC[v][7:0], 1'b1, 1'b0);
            read_lo();
            // R8
            check("R8", {17'd0, buf_full}, 18'd0);
        end

        sync_mode = 1'b0; len_sel = 2'b01; msb_first = 1'b0;
        send_word(9'h011, 8, 1'b0);
        send_word(9'h022, 8, 1'b0);
        // R9 overwrite and flag
        check_all("R9 overwrite", 8'h22, 8'h00, 1'b1, 1'b1);
        read_lo();
        // R9 sticky past read
        check_all("R9 sticky", 8'h22, 8'h00, 1'b0, 1'b1);

        @(negedge clk); rx_en = 1'b0;
        @(negedge clk);
        // R11 toggle clears
        check_all("R11 off", 8'h00, 8'h00, 1'b0, 1'b0);
        send_word(9'h0FF, 5, 1'b0);
        check_all("R11 ignored", 8'h00, 8'h00, 1'b0, 1'b0);
        rx_en = 1'b1;
        send_word(9'h0C3, 8, 1'b0);
        // R11 partial word discarded
        check_all("R11 restart", 8'hC3, 8'h01, 1'b1, 1'b0);
        read_lo();

        send_word(9'h033, 8, 1'b0);
        send_word(9'h044, 8, 1'b1);
        // R10
        check_all("R10", 8'h44, 8'h00, 1'b1, 1'b0);

        done_run = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule